// File: doc/BRIEF.md
# Dual-Clock FIFO with One-Hot Row/Column Addressing

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. By default it holds 16 words. The words sit in a small register array organised as rows and columns. Each side picks its current entry with a one-hot select, formed where an active row line meets an active column line. Each row code and each column code comes from a short Johnson counter. Adjacent counter bits are XORed to give one hot line per counter state. A column counter steps on every accepted operation, and the row counter steps when the column counter leaves its last state.

Each side also keeps its position as one Johnson code that covers the whole ring. Only one bit of that code changes per step, so it can cross to the other domain through a plain two-flop synchronizer. Full and empty are decided in each domain by comparing its own code with the synchronized code of the far side. When the two codes match, a direction bit settles the case. The direction bit is updated only from the quadrants of the two pointers, which are two bits of each code, so the flag logic stays the same size at any depth.

The producer raises a write enable with a word and must watch full. The consumer raises a read enable and must watch empty. For the flags to stay correct, a synchronized pointer may advance by at most one quadrant of the ring between two sampling edges. In practice this means neither clock may run more than a quarter-depth times faster than the other.

Top module: `ohf_dcfifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, with no word lost, duplicated or altered.
- R2: With the default of 2-bit row and column counters the FIFO holds exactly 16 words. After 15 writes without reads `wrFull` stays 0. The 16th write sets `wrFull` to 1 at the write-clock edge that accepts it. Once every stored word has been read, `rdEmpty` returns to 1.
- R3: A write attempted while `wrFull` is 1 is dropped. It moves no pointer and overwrites no stored word, and the dropped value never appears at `rdData`.
- R4: A read attempted while `rdEmpty` is 1 is dropped. `rdData` keeps its previous value and no pointer moves.
- R5: `rdData` is a register. It takes the selected word at the read-clock edge that accepts a read and holds its value at every other edge.
- R6: While a side's active-low reset is held, its pointers return to entry 0. Once reset is released, `rdEmpty` is 1, `wrFull` is 0 and `rdData` is 0. Reset asserts asynchronously and is released through a two-stage synchronizer in each domain.
- R7: Each side selects exactly one entry at a time. Its ring code changes in exactly one bit per accepted operation and in no bit otherwise. As a result, 16 distinct words written in a row come back as 16 distinct words.
- R8: When writes and reads run at the same time on both clocks, including while the flags toggle, the number of words read equals the number of words accepted.
- R9: Flag release is bounded. After a read frees a full FIFO, `wrFull` clears within 6 write-clock cycles. After a write into an empty FIFO, `rdEmpty` clears within 4 read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-domain clock |
| wrRstN | input | 1 | Write-domain reset, active low, asynchronous assert |
| wrEn | input | 1 | Write request; accepted when `wrFull` is 0 |
| wrData | input | W | Word to store |
| wrFull | output | 1 | No free entry; writes are dropped |
| rdClk | input | 1 | Read-domain clock |
| rdRstN | input | 1 | Read-domain reset, active low, asynchronous assert |
| rdEn | input | 1 | Read request; accepted when `rdEmpty` is 0 |
| rdData | output | W | Registered word from the last accepted read |
| rdEmpty | output | 1 | No stored word; reads are dropped |

## Verification
The interesting overlap is a write arriving at the moment the reader frees an entry near the full boundary. A close second is a read draining the last word while a new write is still crossing toward the read domain. The bench provokes both with long runs in which the producer writes faster than the consumer drains, so the FIFO sits full for many cycles. A second run reverses the balance so the FIFO sits at empty. A scoreboard queue is fed only by writes that the bench itself judges accepted from the sampled full flag. Each registered read word is compared in order, and the total counts read and written must match at the end.

// File: rtl/ohf_pkg.sv
`timescale 1ns/1ps
package ohf_pkg;

  // Strobe bundle sent from a side controller to the storage array.
  typedef struct packed {
    logic fire;
  } ohfStrobe_t;

  // Quadrant codes run 00 -> 01 -> 11 -> 10 -> 00 (two-bit Johnson order).
  function automatic logic [1:0] quadNext(input logic [1:0] q);
    return {q[0], ~q[1]};
  endfunction

endpackage

// File: rtl/ohf_johnson_ctr.sv
`timescale 1ns/1ps
module ohf_johnson_ctr #(
  parameter int K = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           step,
  output logic [K-1:0]   code,
  output logic [2*K-1:0] sel
);

  localparam int STATES = 2 * K;

  logic [K-1:0] codeNext;

  generate
    if (K == 1) begin : g_one
      assign codeNext = ~code;
    end else begin : g_many
      assign codeNext = {code[K-2:0], ~code[K-1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     code <= '0;
    else if (step) code <= codeNext;
  end

  // One-hot decode: a single bit boundary marks the state; bit 0 tells the
  // rising half of the cycle from the falling half.
  generate
    for (genvar i = 0; i < STATES; i++) begin : g_dec
      localparam int P = i % K;
      localparam bit HI = (i >= K);
      if (P == 0) begin : g_edge
        assign sel[i] = ~(code[K-1] ^ code[0]) & (code[0] == HI);
      end else begin : g_mid
        assign sel[i] = (code[P] ^ code[P-1]) & (code[0] != HI);
      end
    end
  endgenerate

endmodule

// File: rtl/ohf_side.sv
`timescale 1ns/1ps
module ohf_side import ohf_pkg::*; #(
  parameter int ROW_J     = 2,
  parameter int COL_J     = 2,
  parameter bit RESET_LAG = 1'b0,
  localparam int ROWS  = 2 * ROW_J,
  localparam int COLS  = 2 * COL_J,
  localparam int DEPTH = ROWS * COLS,
  localparam int PJ    = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rstInN,
  input  logic             req,
  input  logic [PJ-1:0]    farPtr,
  output logic             blocked,
  output ohfStrobe_t       strobe,
  output logic [DEPTH-1:0] sel,
  output logic [PJ-1:0]    ptr
);

  logic              rstMeta, localRstN;
  logic [ROW_J-1:0]  rowCode;
  logic [COL_J-1:0]  colCode;
  logic [ROWS-1:0]   rowSel;
  logic [COLS-1:0]   colSel;
  logic              fire, colLast;
  logic [PJ-1:0]     farS1, farS2;
  logic [1:0]        myQuad, farQuad;
  logic              nearBehind, farBehind, lagFlag;

  // Reset: asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rstInN) begin
    if (!rstInN) {localRstN, rstMeta} <= 2'b00;
    else         {localRstN, rstMeta} <= {rstMeta, 1'b1};
  end

  assign fire    = req & ~blocked & localRstN;
  assign colLast = colSel[COLS-1];
  assign strobe  = '{fire: fire};

  ohf_johnson_ctr #(.K(COL_J)) u_col (
    .clk(clk), .rstN(localRstN), .step(fire), .code(colCode), .sel(colSel)
  );

  ohf_johnson_ctr #(.K(ROW_J)) u_row (
    .clk(clk), .rstN(localRstN), .step(fire & colLast), .code(rowCode), .sel(rowSel)
  );

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
        assign sel[r*COLS + c] = rowSel[r] & colSel[c];
      end
    end
  endgenerate

  // Ring position as one Johnson code, safe to synchronize bit by bit.
  always_ff @(posedge clk or negedge localRstN) begin
    if (!localRstN) ptr <= '0;
    else if (fire)  ptr <= {ptr[PJ-2:0], ~ptr[PJ-1]};
  end

  always_ff @(posedge clk or negedge localRstN) begin
    if (!localRstN) begin
      farS1 <= '0;
      farS2 <= '0;
    end else begin
      farS1 <= farPtr;
      farS2 <= farS1;
    end
  end

  assign myQuad     = {ptr[PJ-1],   ptr[PJ/2-1]};
  assign farQuad    = {farS2[PJ-1], farS2[PJ/2-1]};
  assign nearBehind = (quadNext(myQuad) == farQuad);
  assign farBehind  = (quadNext(farQuad) == myQuad);

  // Write side: lag set means equal pointers are full. Read side: lag set
  // means equal pointers are empty. Only the reset value differs.
  always_ff @(posedge clk or negedge localRstN) begin
    if (!localRstN)     lagFlag <= RESET_LAG;
    else if (nearBehind) lagFlag <= 1'b1;
    else if (farBehind)  lagFlag <= 1'b0;
  end

  assign blocked = (ptr == farS2) & lagFlag;

  // R7: exactly one entry selected
  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!localRstN)
    $countones(sel) == 1);

  // R7: the ring code moves by one bit per accepted operation
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!localRstN)
    fire |=> $countones(ptr ^ $past(ptr)) == 1);

  // R3 on the write side, R4 on the read side: a blocked request moves nothing
  p_blocked_hold_r3: assert property (@(posedge clk) disable iff (!localRstN)
    (req && blocked) |=> ($stable(ptr) && $stable(rowCode) && $stable(colCode)));

  // R7: no request, no movement
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!localRstN)
    !req |=> $stable(ptr));

endmodule

// File: rtl/ohf_storage.sv
`timescale 1ns/1ps
module ohf_storage import ohf_pkg::*; #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic             wrClk,
  input  ohfStrobe_t       wrStb,
  input  logic [DEPTH-1:0] wrSel,
  input  logic [W-1:0]     wrData,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  ohfStrobe_t       rdStb,
  input  logic [DEPTH-1:0] rdSel,
  output logic [W-1:0]     rdData
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] pick;

  always_ff @(posedge wrClk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wrStb.fire && wrSel[i]) mem[i] <= wrData;
    end
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < DEPTH; i++) pick |= mem[i] & {W{rdSel[i]}};
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)         rdData <= '0;
    else if (rdStb.fire) rdData <= pick;
  end

  // R5: output register holds without an accepted read
  p_rd_hold_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdStb.fire |=> $stable(rdData));

  // R7: a write lands in exactly one entry
  p_wr_onehot_r7: assert property (@(posedge wrClk)
    wrStb.fire |-> $countones(wrSel) == 1);

endmodule

// File: rtl/ohf_dcfifo.sv
`timescale 1ns/1ps
module ohf_dcfifo import ohf_pkg::*; #(
  parameter int W     = 16,
  parameter int ROW_J = 2,
  parameter int COL_J = 2,
  localparam int DEPTH = 4 * ROW_J * COL_J,
  localparam int PJ    = DEPTH / 2
) (
  input  logic         wrClk,
  input  logic         wrRstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic         wrFull,
  input  logic         rdClk,
  input  logic         rdRstN,
  input  logic         rdEn,
  output logic [W-1:0] rdData,
  output logic         rdEmpty
);

  ohfStrobe_t       wrStb, rdStb;
  logic [DEPTH-1:0] wrSel, rdSel;
  logic [PJ-1:0]    wrPtr, rdPtr;

  ohf_side #(.ROW_J(ROW_J), .COL_J(COL_J), .RESET_LAG(1'b0)) u_wrSide (
    .clk(wrClk), .rstInN(wrRstN), .req(wrEn), .farPtr(rdPtr),
    .blocked(wrFull), .strobe(wrStb), .sel(wrSel), .ptr(wrPtr)
  );

  ohf_side #(.ROW_J(ROW_J), .COL_J(COL_J), .RESET_LAG(1'b1)) u_rdSide (
    .clk(rdClk), .rstInN(rdRstN), .req(rdEn), .farPtr(wrPtr),
    .blocked(rdEmpty), .strobe(rdStb), .sel(rdSel), .ptr(rdPtr)
  );

  ohf_storage #(.W(W), .DEPTH(DEPTH)) u_store (
    .wrClk(wrClk), .wrStb(wrStb), .wrSel(wrSel), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdStb(rdStb), .rdSel(rdSel), .rdData(rdData)
  );

endmodule

// File: tb/sim_ohf_dcfifo.sv
`timescale 1ns/1ps
module sim_ohf_dcfifo;
  localparam int W = 16;

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0, wrEn = 0, rdEn = 0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic wrFull, rdEmpty;

  always #4   wrClk = ~wrClk;   // 125 MHz
  always #6.5 rdClk = ~rdClk;

  ohf_dcfifo #(.W(W)) u0 (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData), .rdEmpty(rdEmpty)
  );

  int checks = 0, errors = 0;
  int wrCount = 0, rdCount = 0, goodReads = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] expRd = '0, lastRd = '0;
  bit pend = 0, done = 0;
  int rdMode = 0;            // 0 idle, 1 always, 2 pseudo-random, 3 single read
  logic [15:0] rdLfsr = 16'hACE1, wrLfsr = 16'h1D2B;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor and read driver
  always begin
    bit en;
    @(negedge rdClk);
    if (pend) begin
      chk(rdData == expRd, "R1 R5 read word in order", rdData, expRd);
      if (rdData == expRd) goodReads++;
      lastRd = rdData;
      rdCount++;
      pend = 0;
    end
    case (rdMode)
      1: en = 1'b1;
      2: begin rdLfsr = {rdLfsr[14:0], rdLfsr[15] ^ rdLfsr[13] ^ rdLfsr[12] ^ rdLfsr[10]}; en = rdLfsr[0]; end
      3: en = 1'b1;
      default: en = 1'b0;
    endcase
    rdEn = en;
    if (en && !rdEmpty) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4 read accepted with nothing written", 1, 0);
      end else begin
        expRd = q.pop_front();
        pend = 1;
      end
      if (rdMode == 3) rdMode = 0;
    end
  end

  task automatic wrCycle(input bit en, input logic [W-1:0] d, output bit acc);
    wrEn = en;
    wrData = d;
    acc = en && !wrFull;
    if (acc) begin
      q.push_back(d);
      wrCount++;
    end
    @(negedge wrClk);
  endtask

  task automatic drain();
    rdMode = 1;
    while (q.size() != 0 || pend) @(negedge wrClk);
    repeat (2) @(negedge rdClk);
    rdMode = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    int n;
    repeat (3) @(negedge wrClk);
    chk(rdEmpty == 1'b1, "R6 empty during reset", rdEmpty, 1);
    wrRstN = 1;
    rdRstN = 1;
    repeat (6) @(negedge wrClk);
    chk(rdEmpty == 1'b1, "R6 empty after reset", rdEmpty, 1);
    chk(wrFull == 1'b0,  "R6 not full after reset", wrFull, 0);
    chk(rdData == '0,    "R6 read data cleared", rdData, 0);

    // Fill to capacity
    for (int i = 0; i < 15; i++) wrCycle(1'b1, 16'h1000 + 16'(i), acc);
    chk(wrFull == 1'b0, "R2 not full after 15 writes", wrFull, 0);
    wrCycle(1'b1, 16'h100F, acc);
    chk(wrFull == 1'b1, "R2 full after 16 writes", wrFull, 1);
    wrCycle(1'b1, 16'hDEAD, acc);
    chk(acc == 1'b0, "R3 write while full not taken", acc, 0);
    wrCycle(1'b0, '0, acc);
    chk(wrFull == 1'b1, "R3 still full after dropped write", wrFull, 1);

    // Full release latency
    goodReads = 0;
    rdMode = 3;
    while (rdMode != 0) @(negedge wrClk);
    n = 0;
    while (wrFull && n < 10) begin @(negedge wrClk); n++; end
    chk(n <= 6, "R9 full clears after a read", n, 6);

    drain();
    chk(goodReads == 16, "R7 sixteen distinct entries returned", goodReads, 16);
    chk(lastRd == 16'h100F, "R3 last stored word survived dropped write", lastRd, 16'h100F);
    chk(rdEmpty == 1'b1, "R2 empty after draining", rdEmpty, 1);

    // Reads while empty are dropped
    rdMode = 1;
    repeat (5) @(negedge rdClk);
    chk(rdData == lastRd, "R4 read data unchanged by read while empty", rdData, lastRd);
    chk(rdEmpty == 1'b1, "R4 still empty", rdEmpty, 1);
    rdMode = 0;

    // Empty release latency
    @(negedge wrClk);
    wrCycle(1'b1, 16'h2001, acc);
    wrEn = 0;
    @(negedge rdClk);
    n = 1;
    while (rdEmpty && n < 10) begin @(negedge rdClk); n++; end
    chk(n <= 4, "R9 empty clears after a write", n, 4);

    // Output holds without a read
    repeat (4) @(negedge rdClk);
    chk(rdData == lastRd, "R5 read data holds without read", rdData, lastRd);
    drain();
    chk(rdData == 16'h2001, "R5 read data updated by accepted read", rdData, 16'h2001);

    // Concurrent traffic, writer faster: sits at full
    rdMode = 2;
    @(negedge wrClk);
    n = 0;
    while (n < 600) begin
      wrLfsr = {wrLfsr[14:0], wrLfsr[15] ^ wrLfsr[13] ^ wrLfsr[12] ^ wrLfsr[10]};
      wrCycle(wrLfsr[0] | wrLfsr[1], 16'h4000 + 16'(n), acc);
      if (acc) n++;
    end
    wrEn = 0;
    drain();

    // Concurrent traffic, reader faster: sits at empty
    rdMode = 1;
    @(negedge wrClk);
    n = 0;
    while (n < 300) begin
      wrLfsr = {wrLfsr[14:0], wrLfsr[15] ^ wrLfsr[13] ^ wrLfsr[12] ^ wrLfsr[10]};
      wrCycle(wrLfsr[0] & wrLfsr[2], 16'h8000 + 16'(n), acc);
      if (acc) n++;
    end
    wrEn = 0;
    drain();

    chk(rdCount == wrCount, "R8 words read equal words accepted", rdCount, wrCount);
    chk(rdEmpty == 1'b1, "R8 empty at end", rdEmpty, 1);
    chk(wrFull == 1'b0, "R8 not full at end", wrFull, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule